// File: doc/BRIEF.md
# Bus-Activity Watchdog Reset Supervisor

This block supervises a host by watching the clock and data lines of a two-wire serial bus. Each START condition on the bus is treated as proof of life: it reloads a watchdog down-counter to its full timeout. If the counter runs out before the next START, the block drives its reset output for a fixed number of cycles. While that pulse lasts, all bus inputs are ignored. A low-voltage flag from an external comparator also holds reset, ends any bus transaction in progress and refuses new work. A nonvolatile write that has already started is allowed to run to completion.

The bus lines and the low-voltage flag pass through a two-flop synchroniser. START (data falls while clock is high) and STOP (data rises while clock is high) are detected on the synchronised samples. A 2-bit select input picks one of three timeouts or switches the watchdog off.

The controller has four named states. PULSE drives reset and counts the pulse length. RUN counts the watchdog. OFF is the disabled watchdog. LOWV holds reset while the low-voltage flag is set. The transitions are:
- PULSE→RUN when the pulse ends and the select is not 3.
- PULSE→OFF when the pulse ends and the select is 3.
- RUN→PULSE when the counter expires.
- RUN→OFF when the select becomes 3.
- OFF→RUN when the select leaves 3.
- any state→LOWV while the synchronised flag is high.
- LOWV→PULSE when the flag clears.

Top module: `bus_wdt_supervisor`

## Requirements
- R1: While `rst_n` is low (a synchronous reset), `reset_out` is 1 and both `bus_busy` and `nvw_busy` are 0.
- R2: After `rst_n` is released, `reset_out` stays high for exactly PULSE_CYC cycles (default 20), counted from the cycle of release.
- R3: The select `tmo_sel` = 0, 1 or 2 picks a timeout T of TMO0, TMO1 or TMO2 cycles (defaults 40, 80, 160). With no further START, `reset_out` rises exactly T+3 cycles after SDA falls while SCL is high. The extra 3 cycles are two synchroniser cycles plus one detection cycle.
- R4: A later START whose SDA fall comes at most T cycles after the previous one reloads the full timeout, so no reset occurs at T+3. A fall at T+1 cycles is too late.
- R5: A watchdog expiry produces a reset pulse of exactly PULSE_CYC cycles.
- R6: A START or STOP arriving during a reset pulse has no effect: the pulse length is unchanged and `bus_busy` stays 0.
- R7: When `tmo_sel` = 3, the watchdog is off and `reset_out` never rises from timeout.
- R8: `bus_busy` rises 3 cycles after a START's SDA fall and falls 3 cycles after a STOP's SDA rise.
- R9: `bus_busy` is 0 in the same cycle that a watchdog expiry raises `reset_out`.
- R10: When `lv_in` goes high, `reset_out` is high 3 cycles later and `bus_busy` is cleared. STARTs seen while the flag is high do not set `bus_busy`.
- R11: An accepted `nvw_start` holds `nvw_busy` high for exactly NVW_CYC cycles (default 50), even if `lv_in` rises meanwhile.
- R12: `nvw_start` is refused (no `nvw_busy`) while `reset_out` is high.
- R13: When `lv_in` falls, `reset_out` stays high through cycle PULSE_CYC+2 after the fall and is low at cycle PULSE_CYC+3. This is a full reset pulse after synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl_in | input | 1 | Serial bus clock line, asynchronous |
| sda_in | input | 1 | Serial bus data line, asynchronous |
| lv_in | input | 1 | Low-voltage flag from an external comparator, active high, asynchronous |
| tmo_sel | input | 2 | Timeout select: 0/1/2 choose TMO0/TMO1/TMO2, 3 disables the watchdog |
| nvw_start | input | 1 | One-cycle request to begin a nonvolatile write |
| reset_out | output | 1 | Active-high reset to the host |
| bus_busy | output | 1 | High from a START until the next STOP, reset or low-voltage event |
| nvw_busy | output | 1 | Nonvolatile write in progress |

## Verification
The bench sweeps the refresh START across T-2 to T+1 cycles for each of the three timeouts. A design that reloads to a partial value, or that gives expiry priority over a START landing on the zero count, fails at the T boundary. STARTs are injected in the middle of a reset pulse. A design that lets them through would stretch or restart the pulse, or raise `bus_busy`. A nonvolatile write overlapped with a low-voltage event shows whether a design wrongly cuts the write short. The exact edges of the pulse after low-voltage release show whether a design skips the full pulse or miscounts the synchroniser latency.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    typedef enum logic [1:0] {
        ST_PULSE,
        ST_RUN,
        ST_OFF,
        ST_LOWV
    } bwd_state_e;

    localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
    parameter int unsigned         WIDTH   = 3,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bwd_cond_det.sv
module bwd_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // data edge while clock held high on both samples
    assign start_evt = scl_p & scl_s &  sda_p & ~sda_s;
    assign stop_evt  = scl_p & scl_s & ~sda_p &  sda_s;
endmodule

// File: rtl/bwd_wdt_fsm.sv
module bwd_wdt_fsm
    import bwd_pkg::*;
#(
    parameter int unsigned TMO0      = 40,
    parameter int unsigned TMO1      = 80,
    parameter int unsigned TMO2      = 160,
    parameter int unsigned PULSE_CYC = 20,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned PCNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tmo_sel,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              lv_s,
    output logic              reset_out,
    output logic              bus_busy,
    output logic              wdt_run,
    output logic [CNT_W-1:0]  wdt_cnt
);
    localparam logic [PCNT_W-1:0] PLOAD = PCNT_W'(PULSE_CYC - 1);

    bwd_state_e         state, nxt;
    logic [PCNT_W-1:0]  pcnt, pcnt_n;
    logic [CNT_W-1:0]   wcnt, wcnt_n;
    logic               busy_q, busy_n;
    logic [CNT_W-1:0]   tmo_load;

    always_comb begin
        unique case (tmo_sel)
            2'd0:    tmo_load = CNT_W'(TMO0 - 1);
            2'd1:    tmo_load = CNT_W'(TMO1 - 1);
            2'd2:    tmo_load = CNT_W'(TMO2 - 1);
            default: tmo_load = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_PULSE;
            pcnt   <= PLOAD;
            wcnt   <= '0;
            busy_q <= 1'b0;
        end else begin
            state  <= nxt;
            pcnt   <= pcnt_n;
            wcnt   <= wcnt_n;
            busy_q <= busy_n;
        end
    end

    // next-state logic
    always_comb begin
        nxt    = state;
        pcnt_n = pcnt;
        wcnt_n = wcnt;
        busy_n = busy_q;
        if (lv_s) begin
            nxt    = ST_LOWV;
            busy_n = 1'b0;
        end else begin
            unique case (state)
                ST_LOWV: begin
                    nxt    = ST_PULSE;
                    pcnt_n = PLOAD;
                    busy_n = 1'b0;
                end
                ST_PULSE: begin
                    busy_n = 1'b0;
                    if (pcnt == '0) begin
                        nxt    = (tmo_sel == SEL_OFF) ? ST_OFF : ST_RUN;
                        wcnt_n = tmo_load;
                    end else begin
                        pcnt_n = pcnt - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (start_evt)     busy_n = 1'b1;
                    else if (stop_evt) busy_n = 1'b0;
                    if (tmo_sel == SEL_OFF) begin
                        nxt = ST_OFF;
                    end else if (start_evt) begin
                        wcnt_n = tmo_load;
                    end else if (wcnt == '0) begin
                        nxt    = ST_PULSE;
                        pcnt_n = PLOAD;
                        busy_n = 1'b0;
                    end else begin
                        wcnt_n = wcnt - 1'b1;
                    end
                end
                ST_OFF: begin
                    if (start_evt)     busy_n = 1'b1;
                    else if (stop_evt) busy_n = 1'b0;
                    if (tmo_sel != SEL_OFF) begin
                        nxt    = ST_RUN;
                        wcnt_n = tmo_load;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        reset_out = (state == ST_PULSE) || (state == ST_LOWV);
        wdt_run   = (state == ST_RUN);
        bus_busy  = busy_q;
        wdt_cnt   = wcnt;
    end
endmodule

// File: rtl/bwd_nvw_timer.sv
module bwd_nvw_timer #(
    parameter int unsigned NVW_CYC = 50,
    parameter int unsigned NCNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              block,
    output logic              busy,
    output logic [NCNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else            cnt  <= cnt - 1'b1;
        end else if (req && !block) begin
            busy <= 1'b1;
            cnt  <= NCNT_W'(NVW_CYC - 1);
        end
    end
endmodule

// File: rtl/bus_wdt_supervisor.sv
module bus_wdt_supervisor #(
    parameter int unsigned TMO0        = 40,
    parameter int unsigned TMO1        = 80,
    parameter int unsigned TMO2        = 160,
    parameter int unsigned PULSE_CYC   = 20,
    parameter int unsigned NVW_CYC     = 50,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       lv_in,
    input  logic [1:0] tmo_sel,
    input  logic       nvw_start,
    output logic       reset_out,
    output logic       bus_busy,
    output logic       nvw_busy
);
    localparam int unsigned T01    = (TMO0 > TMO1) ? TMO0 : TMO1;
    localparam int unsigned T_MAX  = (T01 > TMO2) ? T01 : TMO2;
    localparam int unsigned CNT_W  = $clog2(T_MAX + 1);
    localparam int unsigned PCNT_W = $clog2(PULSE_CYC + 1);
    localparam int unsigned NCNT_W = $clog2(NVW_CYC + 1);

    logic [2:0]        sync_q;
    logic              scl_s, sda_s, lv_s;
    logic              start_evt, stop_evt;
    logic              wdt_run;
    logic [CNT_W-1:0]  wdt_cnt;
    logic [NCNT_W-1:0] nvw_cnt;

    bwd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lv_in, sda_in, scl_in}),
        .q     (sync_q)
    );
    assign scl_s = sync_q[0];
    assign sda_s = sync_q[1];
    assign lv_s  = sync_q[2];

    bwd_cond_det det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    bwd_wdt_fsm #(
        .TMO0(TMO0), .TMO1(TMO1), .TMO2(TMO2),
        .PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W), .PCNT_W(PCNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo_sel   (tmo_sel),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .lv_s      (lv_s),
        .reset_out (reset_out),
        .bus_busy  (bus_busy),
        .wdt_run   (wdt_run),
        .wdt_cnt   (wdt_cnt)
    );

    bwd_nvw_timer #(.NVW_CYC(NVW_CYC), .NCNT_W(NCNT_W)) nvw_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (nvw_start),
        .block (reset_out),
        .busy  (nvw_busy),
        .cnt   (nvw_cnt)
    );
endmodule

// File: rtl/bus_wdt_supervisor_chk.sv
module bus_wdt_supervisor_chk #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned NCNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        tmo_sel,
    input logic              reset_out,
    input logic              bus_busy,
    input logic              nvw_busy,
    input logic              start_evt,
    input logic              lv_s,
    input logic              wdt_run,
    input logic [CNT_W-1:0]  wdt_cnt,
    input logic [NCNT_W-1:0] nvw_cnt
);
    a_r3_expiry_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_run && wdt_cnt == '0 && !start_evt && !lv_s && tmo_sel != 2'b11) |=> reset_out);

    a_r4_refresh_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_run && start_evt && !lv_s && tmo_sel != 2'b11) |=> !reset_out);

    a_r6_start_in_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_out && start_evt) |=> !bus_busy);

    a_r9_no_busy_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |-> !bus_busy);

    a_r10_lv_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        lv_s |=> reset_out);

    a_r11_nvw_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (nvw_busy && nvw_cnt != '0) |=> nvw_busy);
endmodule

bind bus_wdt_supervisor bus_wdt_supervisor_chk #(.CNT_W(CNT_W), .NCNT_W(NCNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmo_sel   (tmo_sel),
    .reset_out (reset_out),
    .bus_busy  (bus_busy),
    .nvw_busy  (nvw_busy),
    .start_evt (start_evt),
    .lv_s      (lv_s),
    .wdt_run   (wdt_run),
    .wdt_cnt   (wdt_cnt),
    .nvw_cnt   (nvw_cnt)
);

// File: tb/bus_wdt_supervisor_tb_top.sv
`timescale 1ns/1ps
module bus_wdt_supervisor_tb_top;
    localparam int TMO0 = 40;
    localparam int TMO1 = 80;
    localparam int TMO2 = 160;
    localparam int PCYC = 20;
    localparam int NVW  = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, lv = 1'b0, nvw_start = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic       reset_out, bus_busy, nvw_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bus_wdt_supervisor #(
        .TMO0(TMO0), .TMO1(TMO1), .TMO2(TMO2),
        .PULSE_CYC(PCYC), .NVW_CYC(NVW), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .lv_in(lv),
        .tmo_sel(tmo_sel), .nvw_start(nvw_start),
        .reset_out(reset_out), .bus_busy(bus_busy), .nvw_busy(nvw_busy)
    );

    function automatic int tmo_of(input int s);
        return (s == 0) ? TMO0 : (s == 1) ? TMO1 : TMO2;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic count_pulse(output int n);
        n = 0;
        while (reset_out && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic do_reset();
        int n;
        scl = 1'b1; sda = 1'b1; lv = 1'b0; nvw_start = 1'b0;
        rst_n = 1'b0;
        tick(); tick();
        chk("R1 reset_out", reset_out, 1);
        chk("R1 bus_busy", bus_busy, 0);
        chk("R1 nvw_busy", nvw_busy, 0);
        rst_n = 1'b1;
        count_pulse(n);
        chk("R2 power-up pulse", n, PCYC);
    endtask

    initial begin
        int n, t, d, hi;
        @(negedge clk);

        // R3 R4 R5 R8: refresh sweep around each timeout
        for (int s = 0; s < 3; s++) begin
            for (int dd = -2; dd <= 1; dd++) begin
                tmo_sel = 2'(s);
                do_reset();
                t = tmo_of(s);
                d = t + dd;
                sda = 1'b0;
                for (int k = 1; k <= t + 3; k++) begin
                    tick();
                    if (k == 3) chk("R8 busy after START", bus_busy, 1);
                    if (k == 7) chk("R8 busy after STOP", bus_busy, 0);
                    if (k == t + 2) chk("R3 no reset before T+3", reset_out, 0);
                    if (k == t + 3) chk("R3/R4 reset at T+3", reset_out, (dd > 0) ? 1 : 0);
                    if (k == 4) sda = 1'b1;
                    if (k == d) sda = 1'b0;
                    if (k == d + 4) sda = 1'b1;
                end
                if (dd > 0) begin
                    count_pulse(n);
                    chk("R5 expiry pulse", n, PCYC);
                end
                sda = 1'b1;
            end
        end

        // R6 R9: expiry with bus held busy, then bus activity inside the pulse
        tmo_sel = 2'd0;
        do_reset();
        sda = 1'b0;
        for (int k = 1; k <= TMO0 + 3; k++) begin
            tick();
            if (k == TMO0 + 2) chk("R9 busy before expiry", bus_busy, 1);
        end
        chk("R9 reset at expiry", reset_out, 1);
        chk("R9 busy cleared at expiry", bus_busy, 0);
        n = 0;
        while (reset_out && n < 1000) begin
            n++;
            if (n == 3) sda = 1'b1;
            if (n == 6) sda = 1'b0;
            if (n == 9) sda = 1'b1;
            if (n == 12) chk("R6 busy in pulse", bus_busy, 0);
            tick();
        end
        chk("R6 pulse length with START", n, PCYC);
        chk("R6 busy after pulse", bus_busy, 0);

        // R7: watchdog disabled
        tmo_sel = 2'd3;
        do_reset();
        hi = 0;
        for (int k = 0; k < 3 * TMO2; k++) begin
            tick();
            if (reset_out) hi++;
        end
        chk("R7 disabled no reset", hi, 0);

        // R10 R12 R13: low-voltage flag
        tmo_sel = 2'd0;
        do_reset();
        sda = 1'b0;
        tick(); tick(); tick();
        chk("R8 busy before LV", bus_busy, 1);
        lv = 1'b1;
        tick(); tick();
        chk("R10 reset not yet", reset_out, 0);
        tick();
        chk("R10 reset under LV", reset_out, 1);
        chk("R10 busy cleared by LV", bus_busy, 0);
        sda = 1'b1;
        repeat (4) tick();
        sda = 1'b0;
        repeat (4) tick();
        chk("R10 START refused under LV", bus_busy, 0);
        chk("R10 reset held", reset_out, 1);
        nvw_start = 1'b1;
        tick();
        nvw_start = 1'b0;
        tick(); tick();
        chk("R12 nvw refused in reset", nvw_busy, 0);
        sda = 1'b1;
        lv = 1'b0;
        for (int k = 1; k <= PCYC + 3; k++) begin
            tick();
            if (k == PCYC + 2) chk("R13 pulse still high", reset_out, 1);
            if (k == PCYC + 3) chk("R13 pulse ended", reset_out, 0);
        end

        // R11: nonvolatile write survives LV
        nvw_start = 1'b1;
        for (int k = 1; k <= NVW + 1; k++) begin
            tick();
            nvw_start = 1'b0;
            if (k == 1) chk("R11 nvw started", nvw_busy, 1);
            if (k == 5) lv = 1'b1;
            if (k == 8) chk("R11 reset under LV", reset_out, 1);
            if (k == NVW) chk("R11 nvw still busy", nvw_busy, 1);
            if (k == NVW + 1) chk("R11 nvw done", nvw_busy, 0);
        end
        lv = 1'b0;
        repeat (5) tick();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule